// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This unit runs one 32x32 multiply or one 32/32 divide at a time over many clock cycles. Both operations share a single adder/subtractor and a single wide shift register. A multiply shifts the register right and adds the multiplicand into its upper half whenever the low bit is set. A divide shifts the register left, trial-subtracts the divisor from the upper part, and shifts in a quotient bit at the right. The upper part is kept unchanged when the trial result is negative.

A host presents the operands, the operation select and a signedness flag together with a one-cycle `start_i`. The unit sets `busy_o` and ignores any further starts until it finishes. It then pulses `done_o` for one cycle, and from that cycle `hi_o`/`lo_o` carry the result. They hold it until the next operation completes. Signed operations convert both operands to magnitudes, run the unsigned core, and then fix the signs of the results. Dividing by zero is not an error: it finishes in the usual number of cycles and gives a defined result.

Top module: `muldiv_seq`

## Requirements
- R1: With `op_div_i`=0 and `op_signed_i`=0, the 64-bit unsigned product of `a_i` and `b_i` appears as `{hi_o, lo_o}` (high word in `hi_o`).
- R2: With `op_div_i`=1 and `op_signed_i`=0 and a nonzero `b_i`, `lo_o` holds the unsigned quotient of `a_i` by `b_i` and `hi_o` holds the remainder.
- R3: With `op_div_i`=0 and `op_signed_i`=1, `{hi_o, lo_o}` is the 64-bit two's-complement product of the signed operands.
- R4: With `op_div_i`=1 and `op_signed_i`=1, the quotient is truncated toward zero and the remainder has the sign of the dividend (-7 by 2 gives quotient -3 and remainder -1). The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: When `b_i` is zero in a divide, the remainder equals `a_i`. The quotient is all ones when unsigned, or when signed with a non-negative dividend. It is +1 when signed with a negative dividend.
- R6: `done_o` goes high for exactly one cycle, 33 clock edges after the edge that accepts `start_i`. `busy_o` is high from the accepting edge until the edge that raises `done_o`, where it falls.
- R7: A `start_i` seen while `busy_o` is high is ignored, including in the last busy cycle. The running operation's result and timing are unchanged, no second `done_o` follows, and `hi_o`/`lo_o` keep the last result while idle.
- R8: After reset, `busy_o`, `done_o`, `hi_o` and `lo_o` are all zero.
- R9: An unsigned divide is exact for divisors with bit 31 set and for a dividend of 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| op_signed_i | input | 1 | 1 = treat operands as two's complement |
| a_i | input | 32 | Multiplier / dividend |
| b_i | input | 32 | Multiplicand / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| hi_o | output | 32 | Product high word / remainder |
| lo_o | output | 32 | Product low word / quotient |

## Verification
The case that matters most is a new start request arriving while an iteration or the final correction step is running. The bench raises `start_i` with different operands in the middle of a multiply, and again in the final busy cycle of a divide, the same cycle in which the result registers are written. It judges each collision by three things: the original result, the exact 33-edge latency, and the absence of any second completion or result change in the idle cycles that follow.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;
endpackage

// File: rtl/md_sign_prep.sv
module md_sign_prep #(
  parameter int W = 32
) (
  input  logic         signed_i,
  input  logic         div_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_main_o,
  output logic         neg_rem_o
);
  logic sa, sb;
  assign sa = signed_i & a_i[W-1];
  assign sb = signed_i & b_i[W-1];

  always_comb begin
    mag_a_o    = sa ? (~a_i + 1'b1) : a_i;
    mag_b_o    = sb ? (~b_i + 1'b1) : b_i;
    neg_main_o = sa ^ sb;             // product or quotient
    neg_rem_o  = div_i & sa;          // remainder follows dividend
  end
endmodule

// File: rtl/md_alu.sv
module md_alu #(
  parameter int W = 32
) (
  input  logic [W:0] x_i,
  input  logic [W:0] y_i,
  input  logic       sub_i,
  output logic [W:0] s_o,
  output logic       co_o
);
  logic [W+1:0] sum;
  always_comb begin
    sum  = {1'b0, x_i} + {1'b0, (sub_i ? ~y_i : y_i)} + {{(W+1){1'b0}}, sub_i};
    s_o  = sum[W:0];
    co_o = sum[W+1];
  end
endmodule

// File: rtl/md_datapath.sv
module md_datapath
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_div_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  input  logic         neg_main_i,
  input  logic         neg_rem_i,
  output logic         busy_o,
  output logic         fix_o,
  output logic         op_div_o,
  output logic         neg_main_o,
  output logic         neg_rem_o,
  output logic [W-1:0] raw_hi_o,
  output logic [W-1:0] raw_lo_o
);
  localparam int AW = 2*W + 1;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W-1);

  md_state_e     state_q;
  logic [AW-1:0] acc_q;
  logic [W-1:0]  opb_q;
  logic [CW-1:0] cnt_q;
  logic          op_div_q, neg_main_q, neg_rem_q;

  logic [W:0]    alu_x, alu_y, alu_s, keep;
  logic          alu_co;
  logic [AW-1:0] step_div, step_mul, load_val;

  // shared adder: add for multiply, subtract for divide
  always_comb begin
    if (op_div_q) begin
      alu_x = acc_q[AW-1:W];
      alu_y = {1'b0, opb_q};
    end else begin
      alu_x = {1'b0, acc_q[2*W-1:W]};
      alu_y = acc_q[0] ? {1'b0, opb_q} : '0;
    end
  end

  md_alu #(.W(W)) u_alu (
    .x_i  (alu_x),
    .y_i  (alu_y),
    .sub_i(op_div_q),
    .s_o  (alu_s),
    .co_o (alu_co)
  );

  always_comb begin
    // carry set means no borrow: trial result kept, quotient bit 1
    keep     = alu_co ? alu_s : alu_x;
    step_div = {keep[W-1:0], acc_q[W-1:0], alu_co};
    step_mul = {1'b0, alu_s, acc_q[W-1:1]};
    load_val = op_div_i ? {{W{1'b0}}, mag_a_i, 1'b0}
                        : {1'b0, {W{1'b0}}, mag_a_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      acc_q      <= '0;
      opb_q      <= '0;
      cnt_q      <= '0;
      op_div_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          acc_q      <= load_val;
          opb_q      <= mag_b_i;
          op_div_q   <= op_div_i;
          neg_main_q <= neg_main_i;
          neg_rem_q  <= neg_rem_i;
          cnt_q      <= '0;
          state_q    <= ST_RUN;
        end
        ST_RUN: begin
          acc_q <= op_div_q ? step_div : step_mul;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o     = (state_q != ST_IDLE);
    fix_o      = (state_q == ST_FIX);
    op_div_o   = op_div_q;
    neg_main_o = neg_main_q;
    neg_rem_o  = neg_rem_q;
    // divide: remainder sits one place too far left; drop that shift
    raw_hi_o   = op_div_q ? acc_q[AW-1:W+1] : acc_q[2*W-1:W];
    raw_lo_o   = acc_q[W-1:0];
  end

  AST_OPND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> ($stable(opb_q) && $stable(op_div_q))) else $error("opnd"); // R7
  AST_MUL_EXT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !op_div_q) |-> !acc_q[AW-1]) else $error("mul ext"); // R1
  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_o && op_div_q && opb_q != '0) |-> (raw_hi_o < opb_q)) else $error("rem"); // R2
  AST_DIV_ZERO_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_o && op_div_q && opb_q == '0) |-> (raw_lo_o == '1)) else $error("divz"); // R5
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_div_i,
  input  logic         op_signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0]   mag_a, mag_b, raw_hi, raw_lo, fin_hi, fin_lo;
  logic           neg_main_in, neg_rem_in, neg_main, neg_rem;
  logic           fix, op_div, busy;
  logic [2*W-1:0] prod;
  logic [W-1:0]   hi_q, lo_q;
  logic           done_q;

  md_sign_prep #(.W(W)) u_prep (
    .signed_i  (op_signed_i),
    .div_i     (op_div_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .mag_a_o   (mag_a),
    .mag_b_o   (mag_b),
    .neg_main_o(neg_main_in),
    .neg_rem_o (neg_rem_in)
  );

  md_datapath #(.W(W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_div_i  (op_div_i),
    .mag_a_i   (mag_a),
    .mag_b_i   (mag_b),
    .neg_main_i(neg_main_in),
    .neg_rem_i (neg_rem_in),
    .busy_o    (busy),
    .fix_o     (fix),
    .op_div_o  (op_div),
    .neg_main_o(neg_main),
    .neg_rem_o (neg_rem),
    .raw_hi_o  (raw_hi),
    .raw_lo_o  (raw_lo)
  );

  always_comb begin
    prod = {raw_hi, raw_lo};
    if (neg_main) prod = ~prod + 1'b1;
    if (op_div) begin
      fin_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
      fin_hi = neg_rem  ? (~raw_hi + 1'b1) : raw_hi;
    end else begin
      fin_hi = prod[2*W-1:W];
      fin_lo = prod[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fix;
      if (fix) begin
        hi_q <= fin_hi;
        lo_q <= fin_lo;
      end
    end
  end

  assign busy_o = busy;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done pulse"); // R6
  AST_DONE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o) else $error("done fall"); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hi_o) && $stable(lo_o))) else $error("hold"); // R7
endmodule

// File: tb/tb_muldiv_seq.sv
module tb_muldiv_seq;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_div = 1'b0, op_sgn = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done;
  logic [W-1:0] hi, lo;

  int total = 0, bad = 0;
  int unsigned seed = 32'h1f2e3d4c;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_seq #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_div_i(op_div),
    .op_signed_i(op_sgn), .a_i(a), .b_i(b), .busy_o(busy), .done_o(done),
    .hi_o(hi), .lo_o(lo)
  );

  function automatic logic [63:0] ref_f(bit dv, bit sg, logic [31:0] x, logic [31:0] y);
    logic [31:0] mx, my, q, r;
    logic [63:0] p;
    bit sx, sy;
    sx = sg & x[31];
    sy = sg & y[31];
    mx = sx ? -x : x;
    my = sy ? -y : y;
    if (!dv) begin
      p = {32'd0, mx} * {32'd0, my};
      if (sx ^ sy) p = -p;
      return p;
    end
    if (my == 0) begin
      q = '1; r = mx;
    end else begin
      q = mx / my; r = mx % my;
    end
    if (sx ^ sy) q = -q;
    if (sx) r = -r;
    return {r, q};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // collide >= 0 raises a junk start at that busy cycle
  task automatic run_op(bit dv, bit sg, logic [31:0] x, logic [31:0] y,
                        string req, int collide);
    logic [63:0] exp;
    int cyc;
    exp = ref_f(dv, sg, x, y);
    @(negedge clk);
    op_div = dv; op_sgn = sg; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      if (cyc == collide) begin
        start = 1'b1; op_div = ~dv; op_sgn = ~sg; a = ~x; b = y ^ 32'h5a5a;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == LAT, "R6 latency", 64'(cyc), 64'(LAT));
    check({hi, lo} == exp, req, {hi, lo}, exp);
    @(negedge clk);
    check(!done && !busy, "R6 done one cycle", {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!busy && !done && hi == 0 && lo == 0, "R8 reset", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R8 idle after reset", {62'd0, busy, done}, 64'd0);

    run_op(0, 0, 32'd3, 32'd5, "R1 small mul", -1);
    run_op(0, 0, '1, '1, "R1 max mul", -1);
    run_op(1, 0, 32'd7, 32'd2, "R2 7/2", -1);
    run_op(1, 0, 32'd5, 32'd9, "R2 a<b", -1);
    run_op(0, 1, -32'sd7, 32'd3, "R3 neg*pos", -1);
    run_op(0, 1, 32'h80000000, 32'h80000000, "R3 min*min", -1);
    run_op(1, 1, -32'sd7, 32'd2, "R4 -7/2", -1);
    run_op(1, 1, 32'd7, -32'sd2, "R4 7/-2", -1);
    run_op(1, 1, 32'h80000000, '1, "R4 min/-1", -1);
    run_op(1, 0, 32'h1234_5678, 32'd0, "R5 udiv by zero", -1);
    run_op(1, 1, -32'sd9, 32'd0, "R5 sdiv by zero neg", -1);
    run_op(1, 1, 32'd9, 32'd0, "R5 sdiv by zero pos", -1);
    run_op(1, 0, '1, 32'h8000_0001, "R9 big divisor", -1);
    run_op(1, 0, '1, '1, "R9 max/max", -1);
    run_op(1, 0, 32'hfffffffe, 32'hc000_0000, "R9 top bit", -1);

    // R7 start collides with iteration and with the final busy cycle
    run_op(0, 0, 32'd3, 32'd5, "R7 collide mid mul", 5);
    run_op(1, 0, 32'd100, 32'd7, "R7 collide last cycle", W);
    repeat (3) @(negedge clk);
    check(!busy && !done && hi == 32'd2 && lo == 32'd14, "R7 no second op",
          {hi, lo}, {32'd2, 32'd14});

    for (int i = 0; i < 300; i++) begin
      bit dv, sg;
      logic [31:0] x, y;
      dv = 1'($urandom);
      sg = 1'($urandom);
      x = $urandom;
      y = $urandom;
      if (i % 4 == 1) y = y >> (y[4:0]);
      run_op(dv, sg, x, y, dv ? (sg ? "R4 rand" : "R2 rand") : (sg ? "R3 rand" : "R1 rand"), -1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule